// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block produces the word address that drives a synchronous memory array during a four-beat burst. When a cycle begins it captures a full starting address. On later clocks, a low advance input walks the two least significant address bits through one of two beat orders. The upper bits stay frozen at the captured value for as long as the burst runs. A static order-select input chooses between the two orders. One is an interleaved order, in which the beat index is XOR-ed into the starting offset. The other is a linear order, in which the offset counts up modulo four.

Two active-low strobes can start a cycle. The controller strobe loads a new address whatever the chip enable is doing. The processor strobe loads only while the active-low chip enable is asserted. A high advance input suspends the burst, and the address holds until advance is asserted again. The output is registered, so a load or a step shows on the output right after the clock edge that samples it.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high reset is applied, the next clock edge sets the output address to zero.
- R2: A clock edge with the controller strobe low loads the input address into the output, whatever the chip enable level.
- R3: The processor strobe loads the input address only when chip enable is low. With chip enable high, a low processor strobe has no effect, and the output holds if advance is high.
- R4: Between loads, the bits above the two sequenced bits keep their captured value.
- R5: With order-select high (interleaved), beat k of a burst gives low bits equal to the starting low bits XOR k, for k = 0..3.
- R6: With order-select low (linear), beat k gives low bits equal to (starting low bits + k) mod 4.
- R7: After the fourth beat, a further advance returns the low bits to the starting value, and the sequence repeats.
- R8: A clock edge with advance high and no load leaves the output unchanged (suspend).
- R9: A load takes priority over an advance in the same cycle and restarts the beat count at zero. A load on each of two back-to-back cycles takes each address in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W (15) | Starting address presented with a strobe |
| ctl_strobe_n | input | 1 | Controller load strobe, active low, not gated by chip enable |
| cpu_strobe_n | input | 1 | Processor load strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| order_ilv | input | 1 | Order select, static: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W (15) | Registered internal word address |

## Verification
The bench builds the block with its default parameters: a 15-bit address with two sequenced bits. This gives four starting offsets and a four-beat burst. At that size every starting offset can be swept in both orders, running five advances so that the wrap back to the start is seen every time. Suspend cycles are placed in the middle of each burst. The non-zero upper address patterns, which change with the offset, show that the upper bits are held. The strobe gating is also covered: controller and processor loads with chip enable in both states, loads on back-to-back cycles, and a load that meets an advance in the same cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_load_dec.sv
module burst_load_dec (
  input  logic ctl_strobe_n,
  input  logic cpu_strobe_n,
  input  logic chip_en_n,
  input  logic adv_n,
  output logic load_o,
  output logic step_o
);
  logic ctl_load;
  logic cpu_load;

  always_comb begin
    ctl_load = ~ctl_strobe_n;
    cpu_load = ~cpu_strobe_n & ~chip_en_n;
    load_o   = ctl_load | cpu_load;
    step_o   = ~load_o & ~adv_n;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int SEQ_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  output logic [SEQ_W-1:0] beat_o,
  output logic [SEQ_W-1:0] beat_nxt_o
);
  logic [SEQ_W-1:0] beat_q;

  always_comb begin
    beat_nxt_o = beat_q;
    if (load_i)      beat_nxt_o = '0;
    else if (step_i) beat_nxt_o = beat_q + SEQ_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt_o;
  end

  assign beat_o = beat_q;

  assert_beat_clear_R9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (beat_o == '0));

  assert_beat_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (beat_o == SEQ_W'($past(beat_o) + SEQ_W'(1))));

  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> $stable(beat_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int SEQ_W = 2
) (
  input  logic [SEQ_W-1:0] base_i,
  input  logic [SEQ_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [SEQ_W-1:0] low_o
);
  logic [SEQ_W-1:0] ilv_low;
  logic [SEQ_W-1:0] lin_low;

  for (genvar i = 0; i < SEQ_W; i++) begin : g_ilv
    assign ilv_low[i] = base_i[i] ^ beat_i[i];
  end

  assign lin_low = base_i + beat_i;

  always_comb begin
    low_o = (order_i == ORD_INTERLEAVE) ? ilv_low : lin_low;
  end

  always_comb begin
    if (beat_i == '0) begin
      assert_zero_beat_R5: assert (low_o == base_i);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int SEQ_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ctl_strobe_n,
  input  logic              cpu_strobe_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - SEQ_W;

  logic              load;
  logic              step;
  logic [SEQ_W-1:0]  beat_q;
  logic [SEQ_W-1:0]  beat_nxt;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_nxt;
  logic [SEQ_W-1:0]  low_nxt;
  logic [ADDR_W-1:0] addr_q;
  burst_order_e      order;

  assign order = burst_order_e'(order_ilv);

  burst_load_dec u_dec (
    .ctl_strobe_n (ctl_strobe_n),
    .cpu_strobe_n (cpu_strobe_n),
    .chip_en_n    (chip_en_n),
    .adv_n        (adv_n),
    .load_o       (load),
    .step_o       (step)
  );

  burst_beat_ctr #(.SEQ_W(SEQ_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .step_i     (step),
    .beat_o     (beat_q),
    .beat_nxt_o (beat_nxt)
  );

  assign base_nxt = load ? addr_in : base_q;

  burst_order_map #(.SEQ_W(SEQ_W)) u_map (
    .base_i  (base_nxt[SEQ_W-1:0]),
    .beat_i  (beat_nxt),
    .order_i (order),
    .low_o   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else begin
      base_q <= base_nxt;
      if (load || step) addr_q <= {base_nxt[ADDR_W-1:SEQ_W], low_nxt};
    end
  end

  assign addr_out = addr_q;

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl_strobe_n |=> (addr_out == $past(addr_in)));

  assert_cpu_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_strobe_n && !cpu_strobe_n && chip_en_n && adv_n) |=> $stable(addr_out));

  assert_upper_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(addr_out[ADDR_W-1:SEQ_W]));

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
    (step && order == ORD_LINEAR) |=>
      (addr_out[SEQ_W-1:0] == SEQ_W'($past(addr_out[SEQ_W-1:0]) + SEQ_W'(1))));

  assert_suspend_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(addr_out));

  assert_load_first_R9: assert property (@(posedge clk) disable iff (rst)
    (load && !adv_n) |=> (addr_out == $past(addr_in)));

  assert_up_width_R4: assert property (@(posedge clk) disable iff (rst)
    (UP_W > 0) |-> (base_q[ADDR_W-1:SEQ_W] == addr_out[ADDR_W-1:SEQ_W]));
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/100ps
module burst_addr_gen_test;
  localparam int ADDR_W = 15;
  localparam int SEQ_W  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              ctl_strobe_n = 1'b1;
  logic              cpu_strobe_n = 1'b1;
  logic              chip_en_n = 1'b1;
  logic              adv_n = 1'b1;
  logic              order_ilv = 1'b0;
  logic [ADDR_W-1:0] addr_out;

  int total = 0;
  int bad = 0;
  logic [ADDR_W-1:0] m_base = '0;
  int m_beat = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) uut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ctl_strobe_n(ctl_strobe_n),
    .cpu_strobe_n(cpu_strobe_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .order_ilv(order_ilv), .addr_out(addr_out)
  );

  function automatic logic [ADDR_W-1:0] model_addr();
    int lo;
    lo = order_ilv ? (int'(m_base[1:0]) ^ m_beat) : ((int'(m_base[1:0]) + m_beat) % 4);
    return {m_base[ADDR_W-1:2], 2'(lo)};
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    total++;
    if (addr_out !== exp) begin
      bad++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample 1 ns after the edge
  task automatic cyc(input logic ctl, input logic cpu, input logic ce,
                     input logic adv, input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    ctl_strobe_n = ctl; cpu_strobe_n = cpu; chip_en_n = ce; adv_n = adv; addr_in = a;
    @(posedge clk);
    if (!ctl || (!cpu && !ce)) begin m_base = a; m_beat = 0; end
    else if (!adv) m_beat = (m_beat + 1) % 4;
    #1;
    check(req, model_addr());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ctl_strobe_n = 1'b1; cpu_strobe_n = 1'b1; adv_n = 1'b1;
    @(posedge clk); #1;
    check("R1", '0);
    @(negedge clk);
    rst = 1'b0; m_base = '0; m_beat = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    for (int ord = 0; ord < 2; ord++) begin
      @(negedge clk); order_ilv = 1'(ord);
      do_reset();
      for (int off = 0; off < 4; off++) begin
        logic [ADDR_W-1:0] a;
        a = {13'(13'h1A5B ^ (off * 13'h0321) ^ (ord * 13'h0777)), 2'(off)};
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a, "R2");
        for (int k = 1; k <= 5; k++) begin
          cyc(1'b1, 1'b1, 1'b0, 1'b0, ~a, (k == 5) ? "R7" : (ord == 1 ? "R5" : "R6"));
          if (k == 2) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b1, ~a, "R8");
            cyc(1'b1, 1'b1, 1'b1, 1'b1, a ^ 15'h7FFC, "R4");
          end
        end
      end
      // processor strobe with chip enable high: ignored
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 15'h2AAA, "R3");
      // processor strobe with chip enable low: loads
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 15'h1235, "R3");
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, "R3");
      // back-to-back loads, second meets advance
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 15'h4442, "R9");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 15'h0883, "R9");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 15'h7001, "R9");
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 15'h0000, "R9");
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 15'h0000, "R4");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule